// File: doc/BRIEF.md
# CAN Controller Host Message Buffer Interface

This block is the host-facing register side of a CAN controller. The host reaches it through a byte-wide register port. There are four control registers and a window of frame bytes. In operating mode a write to the window fills a transmit buffer, and a read from the window returns the frame held in a receive buffer. In reset mode the same window instead holds a 32-bit acceptance code and a 32-bit acceptance mask, which decide which incoming frames are stored.

A frame has one information byte, then identifier bytes, then data bytes. The information byte carries the extended-frame flag, the remote flag and the length code. A standard identifier takes two bytes and an extended identifier takes four, so the data starts at a different byte for each. The bus itself is not modelled. Transmit frames go out on a valid/acknowledge sink, and received frames arrive as single-cycle pulses from a frame source. A self-test mode can loop the transmit buffer straight into the receive buffer. Flags that clear on read report receive and transmit-complete events.

Top module: `can_msgbuf_host`

## Requirements
- R1: After reset the mode register (offset 0) reads 0x01 (reset mode), the status register (offset 2) reads 0x04, the interrupt register (offset 3) reads 0x00, and tx_valid_o and irq_o are low.
- R2: Mode bit 0 selects reset mode, bit 1 listen-only, bit 2 self-test and bit 3 filter mode. Bit 0 can always be written. Bits 3:1 change only while reset mode is currently set.
- R3: In reset mode, window offsets 0..3 read and write the acceptance code and offsets 4..7 read and write the acceptance mask, with the most significant byte at the lower offset. After reset the code is 0 and the mask is all ones. Other window offsets read 0 in reset mode.
- R4: The window starts at address 16 and spans 13 bytes. Byte 0 is the information byte: bit 7 extended, bit 6 remote, bits 3:0 length code. A standard frame has 3 header bytes and an extended frame has 5. A length code above 8 counts as 8. On tx_frame_o, which carries byte i at bits 8i+7:8i, every byte at or beyond the header plus the clipped length is zero.
- R5: A command write with bit 0 (transmit request) outside reset and listen-only sets tx_valid_o from the next cycle and clears status bit 2 (transmit buffer free). While the request is pending, writes to the window are ignored.
- R6: A tx_ack_i pulse while tx_valid_o is high ends the transmission. tx_valid_o drops, status bit 2 returns to 1, and interrupt bit 1 is set.
- R7: Command bit 1 (abort), or a mode write that sets bit 0, drops a pending transmission without setting interrupt bit 1.
- R8: Command writes have no effect in reset mode. A transmit request has no effect in listen-only mode.
- R9: An incoming frame that arrives outside reset mode, while the receive buffer is empty and the filter passes, is stored with the same clipping as R4. The stored frame is readable in the window, and status bit 0 and interrupt bit 0 are set.
- R10: A frame passes the filter when ((frame bytes 1..4 as a 32-bit word, byte 1 most significant) XOR code) AND NOT mask is zero. Frames arriving in reset mode are dropped.
- R11: A frame that arrives while the buffer is full sets status bit 1 (overrun) and leaves the buffer unchanged. Command bit 3 clears the overrun. Command bit 2 releases the buffer and clears status bit 0. A frame arriving in the same cycle as a release is stored.
- R12: Reading offset 3 returns the latched flags and clears them. A flag raised in the same cycle as that read stays set. irq_o is the OR of the latched flags.
- R13: In self-test mode, command bit 4 (self-reception request) copies the transmit buffer into the receive buffer in one cycle, without tx_valid_o and without an acknowledge. It sets interrupt bits 0 and 1. Outside self-test mode this bit does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Host write strobe |
| rd_en_i | input | 1 | Host read strobe |
| addr_i | input | 5 | Host byte address |
| wdata_i | input | 8 | Host write data |
| rdata_o | output | 8 | Read data, valid the cycle after rd_en_i |
| irq_o | output | 1 | Any latched interrupt flag |
| rx_valid_i | input | 1 | Incoming frame pulse |
| rx_frame_i | input | 104 | Incoming frame, byte i at bits 8i+7:8i |
| tx_valid_o | output | 1 | Transmit frame offered |
| tx_frame_o | output | 104 | Transmit frame, clipped as in R4 |
| tx_ack_i | input | 1 | Transmission done, while tx_valid_o is high |

## Verification
The assertions assume that tx_ack_i is raised only while tx_valid_o is high. They also assume that the host never issues a read and a write in the same cycle. The stimulus keeps to both. Acknowledges are pulsed only after the bench has seen tx_valid_o high. Every host access is a separate one-cycle strobe, applied on the falling edge. Incoming frame pulses are placed in the same cycle as a release command or an interrupt read only in the race scenarios, where that overlap is the point of the test. They never overlap a self-reception request.

// File: rtl/can_mb_pkg.sv
package can_mb_pkg;
    localparam int unsigned HDR_STD = 3;
    localparam int unsigned HDR_EXT = 5;

    localparam int unsigned REG_MODE = 0;
    localparam int unsigned REG_CMD  = 1;
    localparam int unsigned REG_STAT = 2;
    localparam int unsigned REG_IRQ  = 3;
    localparam int unsigned WIN_BASE = 16;

    localparam int unsigned MODE_RST    = 0;
    localparam int unsigned MODE_LISTEN = 1;
    localparam int unsigned MODE_SELF   = 2;

    localparam int unsigned CMD_TX      = 0;
    localparam int unsigned CMD_ABORT   = 1;
    localparam int unsigned CMD_RELEASE = 2;
    localparam int unsigned CMD_CLROVR  = 3;
    localparam int unsigned CMD_SELFRX  = 4;

    localparam int unsigned INFO_EXT = 7;

    // Number of meaningful bytes in a frame: header plus clipped length.
    function automatic int unsigned frame_used(input logic ext, input logic [3:0] dlc,
                                               input int unsigned dmax);
        int unsigned n;
        n = (32'(dlc) > dmax) ? dmax : 32'(dlc);
        return (ext ? HDR_EXT : HDR_STD) + n;
    endfunction
endpackage

// File: rtl/can_mb_tx.sv
module can_mb_tx
    import can_mb_pkg::*;
#(
    parameter int unsigned FB   = 13,
    parameter int unsigned DMAX = 8,
    parameter int unsigned IW   = 4
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 wr_i,
    input  logic [IW-1:0]        widx_i,
    input  logic [7:0]           wdata_i,
    input  logic                 req_i,
    input  logic                 abort_i,
    input  logic                 stop_i,
    input  logic                 ack_i,
    output logic                 pend_o,
    output logic                 done_o,
    output logic [FB-1:0][7:0]   frame_o
);
    typedef struct packed {
        logic [FB-1:0][7:0] mem;
        logic               pend;
    } tx_st_t;

    tx_st_t st_d, st_q;
    int unsigned used;

    always_comb begin
        st_d   = st_q;
        done_o = st_q.pend && ack_i && !stop_i;
        if (wr_i && !st_q.pend) begin
            st_d.mem[widx_i] = wdata_i;
        end
        if (stop_i || abort_i || done_o) begin
            st_d.pend = 1'b0;
        end else if (req_i) begin
            st_d.pend = 1'b1;
        end
        used = frame_used(st_q.mem[0][INFO_EXT], st_q.mem[0][3:0], DMAX);
        for (int unsigned i = 0; i < FB; i++) begin
            frame_o[i] = (i < used) ? st_q.mem[i] : 8'h00;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign pend_o = st_q.pend;

    AST_TX_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && st_q.pend) |=> $stable(st_q.mem)); // R5
    AST_TX_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stop_i || abort_i) |=> !st_q.pend); // R7
    AST_TX_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.pend && ack_i) |=> !st_q.pend); // R6
endmodule

// File: rtl/can_mb_rx.sv
module can_mb_rx
    import can_mb_pkg::*;
#(
    parameter int unsigned FB   = 13,
    parameter int unsigned DMAX = 8
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 cap_vld_i,
    input  logic [FB-1:0][7:0]   cap_i,
    input  logic                 release_i,
    input  logic                 clrovr_i,
    input  logic                 stop_i,
    input  logic [31:0]          code_i,
    input  logic [31:0]          mask_i,
    output logic [FB-1:0][7:0]   mem_o,
    output logic                 full_o,
    output logic                 ovr_o,
    output logic                 got_o
);
    typedef struct packed {
        logic [FB-1:0][7:0] mem;
        logic               full;
        logic               ovr;
    } rx_st_t;

    rx_st_t st_d, st_q;
    logic [FB-1:0][7:0] clipped;
    logic [31:0] id_word;
    logic acc, room;
    int unsigned used;

    always_comb begin
        id_word = {cap_i[1], cap_i[2], cap_i[3], cap_i[4]};
        acc     = cap_vld_i && !stop_i && (((id_word ^ code_i) & ~mask_i) == 32'h0);
        room    = !st_q.full || release_i;
        used    = frame_used(cap_i[0][INFO_EXT], cap_i[0][3:0], DMAX);
        for (int unsigned i = 0; i < FB; i++) begin
            clipped[i] = (i < used) ? cap_i[i] : 8'h00;
        end
        st_d  = st_q;
        got_o = acc && room;
        if (clrovr_i) st_d.ovr = 1'b0;
        if (release_i) st_d.full = 1'b0;
        if (got_o) begin
            st_d.mem  = clipped;
            st_d.full = 1'b1;
        end else if (acc) begin
            st_d.ovr = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign mem_o  = st_q.mem;
    assign full_o = st_q.full;
    assign ovr_o  = st_q.ovr;

    AST_RX_OVERRUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.full && acc && !release_i) |=> (st_q.ovr && $stable(st_q.mem))); // R11
    AST_RX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.full && !release_i) |=> st_q.full); // R11
endmodule

// File: rtl/can_msgbuf_host.sv
module can_msgbuf_host
    import can_mb_pkg::*;
#(
    parameter int unsigned ADDR_W = 5,
    parameter int unsigned DMAX   = 8
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic                       wr_en_i,
    input  logic                       rd_en_i,
    input  logic [ADDR_W-1:0]          addr_i,
    input  logic [7:0]                 wdata_i,
    output logic [7:0]                 rdata_o,
    output logic                       irq_o,
    input  logic                       rx_valid_i,
    input  logic [(HDR_EXT+DMAX)*8-1:0] rx_frame_i,
    output logic                       tx_valid_o,
    output logic [(HDR_EXT+DMAX)*8-1:0] tx_frame_o,
    input  logic                       tx_ack_i
);
    localparam int unsigned FB = HDR_EXT + DMAX;
    localparam int unsigned IW = $clog2(FB);

    typedef struct packed {
        logic [3:0]      mode;
        logic [3:0][7:0] code;
        logic [3:0][7:0] mask;
        logic [1:0]      irq;
        logic [7:0]      rdata;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [ADDR_W-1:0] win_off;
    logic [IW-1:0] widx;
    logic in_win, in_rst, mode_wr, cmd_wr, stop, tx_req, loop_go;
    logic tx_pend, tx_done, rx_full, rx_ovr, rx_got;
    logic [FB-1:0][7:0] tx_frm, rx_mem, rx_in, cap;

    assign win_off = addr_i - ADDR_W'(WIN_BASE);
    assign in_win  = (addr_i >= ADDR_W'(WIN_BASE)) && (win_off < ADDR_W'(FB));
    assign widx    = win_off[IW-1:0];
    assign in_rst  = st_q.mode[MODE_RST];
    assign mode_wr = wr_en_i && (addr_i == ADDR_W'(REG_MODE));
    assign cmd_wr  = wr_en_i && (addr_i == ADDR_W'(REG_CMD)) && !in_rst;
    assign stop    = in_rst || (mode_wr && wdata_i[MODE_RST]);
    assign tx_req  = cmd_wr && wdata_i[CMD_TX] && !st_q.mode[MODE_LISTEN];
    assign loop_go = cmd_wr && wdata_i[CMD_SELFRX] && st_q.mode[MODE_SELF] && !tx_pend;
    assign rx_in   = rx_frame_i;
    assign cap     = loop_go ? tx_frm : rx_in;

    can_mb_tx #(.FB(FB), .DMAX(DMAX), .IW(IW)) u_tx (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .wr_i    (wr_en_i && in_win && !in_rst),
        .widx_i  (widx),
        .wdata_i (wdata_i),
        .req_i   (tx_req),
        .abort_i (cmd_wr && wdata_i[CMD_ABORT]),
        .stop_i  (stop),
        .ack_i   (tx_ack_i),
        .pend_o  (tx_pend),
        .done_o  (tx_done),
        .frame_o (tx_frm)
    );

    can_mb_rx #(.FB(FB), .DMAX(DMAX)) u_rx (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .cap_vld_i (rx_valid_i || loop_go),
        .cap_i     (cap),
        .release_i (cmd_wr && wdata_i[CMD_RELEASE]),
        .clrovr_i  (cmd_wr && wdata_i[CMD_CLROVR]),
        .stop_i    (in_rst),
        .code_i    ({st_q.code[0], st_q.code[1], st_q.code[2], st_q.code[3]}),
        .mask_i    ({st_q.mask[0], st_q.mask[1], st_q.mask[2], st_q.mask[3]}),
        .mem_o     (rx_mem),
        .full_o    (rx_full),
        .ovr_o     (rx_ovr),
        .got_o     (rx_got)
    );

    always_comb begin
        st_d = st_q;
        if (mode_wr) begin
            st_d.mode[MODE_RST] = wdata_i[MODE_RST];
            if (in_rst) st_d.mode[3:1] = wdata_i[3:1];
        end
        if (wr_en_i && in_win && in_rst && (widx < IW'(8))) begin
            if (widx < IW'(4)) st_d.code[widx[1:0]] = wdata_i;
            else               st_d.mask[widx[1:0]] = wdata_i;
        end
        st_d.rdata = 8'h00;
        if (rd_en_i) begin
            if (addr_i == ADDR_W'(REG_MODE))      st_d.rdata = {4'h0, st_q.mode};
            else if (addr_i == ADDR_W'(REG_STAT)) st_d.rdata = {5'h0, !tx_pend, rx_ovr, rx_full};
            else if (addr_i == ADDR_W'(REG_IRQ))  st_d.rdata = {6'h0, st_q.irq};
            else if (in_win && in_rst) begin
                if (widx < IW'(4))      st_d.rdata = st_q.code[widx[1:0]];
                else if (widx < IW'(8)) st_d.rdata = st_q.mask[widx[1:0]];
            end else if (in_win) begin
                st_d.rdata = rx_mem[widx];
            end
        end
        if (rd_en_i && (addr_i == ADDR_W'(REG_IRQ))) st_d.irq = 2'b00;
        if (rx_got)            st_d.irq[0] = 1'b1;
        if (tx_done || loop_go) st_d.irq[1] = 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q      <= '0;
            st_q.mode <= 4'h1;
            st_q.mask <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata_o    = st_q.rdata;
    assign irq_o      = |st_q.irq;
    assign tx_valid_o = tx_pend;
    assign tx_frame_o = tx_frm;

    AST_IRQ_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_en_i && addr_i == ADDR_W'(REG_IRQ) && !rx_got && !tx_done && !loop_go)
        |=> !irq_o); // R12
    AST_RST_NO_TX: assert property (@(posedge clk_i) disable iff (!rst_ni)
        in_rst |=> !$rose(tx_valid_o)); // R8
    AST_LISTEN_NO_TX: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.mode[MODE_LISTEN] && !in_rst) |=> !$rose(tx_valid_o)); // R8
    AST_LOOP_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (loop_go && !rx_full) |=> (rx_full && st_q.irq == 2'b11 && !tx_valid_o)); // R13
    AST_ACK_ONLY_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tx_ack_i |-> tx_valid_o); // R6
    AST_MODE_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !in_rst |=> (st_q.mode[3:1] == $past(st_q.mode[3:1]))); // R2
endmodule

// File: tb/can_msgbuf_host_bench.sv
`timescale 1ns/1ps
module can_msgbuf_host_bench;
    typedef logic [12:0][7:0] frm_t;

    logic clk = 1'b0, rst_n = 1'b0;
    logic wr_en = 0, rd_en = 0, rx_valid = 0, tx_ack = 0;
    logic [4:0] addr = '0;
    logic [7:0] wdata = '0, rdata;
    logic irq, tx_valid;
    frm_t rx_frame = '0, tx_frame;
    int checks = 0, errors = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    can_msgbuf_host u_can_msgbuf_host (
        .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr),
        .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .rx_valid_i(rx_valid),
        .rx_frame_i(rx_frame), .tx_valid_o(tx_valid), .tx_frame_o(tx_frame), .tx_ack_i(tx_ack)
    );

    function automatic frm_t clip(frm_t f);
        int n;
        frm_t r = '0;
        n = (f[0][7] ? 5 : 3) + ((f[0][3:0] > 4'd8) ? 8 : int'(f[0][3:0]));
        for (int i = 0; i < 13; i++) if (i < n) r[i] = f[i];
        return r;
    endfunction

    task automatic chk8(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chkf(string tag, frm_t act, frm_t exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1; addr = a; wdata = d;
        @(posedge clk); #1; wr_en = 0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk); rd_en = 1; addr = a;
        @(posedge clk); #1; d = rdata; rd_en = 0;
    endtask

    task automatic push(input frm_t f);
        @(negedge clk); rx_valid = 1; rx_frame = f;
        @(posedge clk); #1; rx_valid = 0;
    endtask

    task automatic ack_pulse();
        @(negedge clk); tx_ack = 1;
        @(posedge clk); #1; tx_ack = 0;
    endtask

    task automatic write_frame(input frm_t f);
        for (int i = 0; i < 13; i++) wr(5'(16 + i), f[i]);
    endtask

    task automatic read_frame(output frm_t f);
        logic [7:0] b;
        for (int i = 0; i < 13; i++) begin rd(5'(16 + i), b); f[i] = b; end
    endtask

    task automatic expect_reg(string tag, logic [4:0] a, logic [7:0] exp);
        logic [7:0] v;
        rd(a, v);
        chk8(tag, v, exp);
    endtask

    task automatic t_reset();
        chk8("R1 tx_valid", {7'b0, tx_valid}, 8'h00);
        chk8("R1 irq_o", {7'b0, irq}, 8'h00);
        expect_reg("R1 mode", 0, 8'h01);
        expect_reg("R1 status", 2, 8'h04);
        expect_reg("R1 irq", 3, 8'h00);
    endtask

    task automatic t_mode();
        wr(0, 8'h0E); expect_reg("R2 all bits in reset", 0, 8'h0E);
        wr(0, 8'h00); expect_reg("R2 bits locked when operating", 0, 8'h0E);
        wr(0, 8'h01); expect_reg("R2 reset bit", 0, 8'h0F);
        wr(0, 8'h00); expect_reg("R2 cleared in reset", 0, 8'h00);
        wr(0, 8'h01);
    endtask

    task automatic t_filter_regs();
        expect_reg("R3 code default", 16, 8'h00);
        expect_reg("R3 mask default", 20, 8'hFF);
        wr(16, 8'h2A); wr(17, 8'h20); wr(18, 8'h00); wr(19, 8'h00);
        wr(20, 8'h00); wr(21, 8'h1F); wr(22, 8'hFF); wr(23, 8'hFF);
        expect_reg("R3 code byte1", 17, 8'h20);
        expect_reg("R3 mask byte1", 21, 8'h1F);
        expect_reg("R3 other offset", 25, 8'h00);
        wr(0, 8'h00);
    endtask

    task automatic t_filter();
        frm_t f = '0;
        f[0] = 8'h01; f[1] = 8'h2A; f[2] = 8'h20; f[3] = 8'h77;
        push(f);
        expect_reg("R10 matching id stored", 2, 8'h05);
        wr(1, 8'h04);
        expect_reg("R11 release clears full", 2, 8'h04);
        f[2] = 8'h40;
        push(f);
        expect_reg("R10 other id dropped", 2, 8'h04);
        expect_reg("R10 irq from match", 3, 8'h01);
        wr(0, 8'h01);
        wr(16, 8'h00); wr(17, 8'h00); wr(20, 8'hFF); wr(21, 8'hFF);
        push(f);
        expect_reg("R10 dropped in reset mode", 2, 8'h04);
        wr(0, 8'h00);
        expect_reg("R10 no irq in reset mode", 3, 8'h00);
    endtask

    task automatic t_tx_std();
        frm_t f = '0, snap;
        f[0] = 8'h03; f[1] = 8'h2A; f[2] = 8'h20;
        f[3] = 8'h11; f[4] = 8'h22; f[5] = 8'h33; f[6] = 8'h99; f[12] = 8'h55;
        write_frame(f);
        wr(1, 8'h01);
        chk8("R5 tx_valid after request", {7'b0, tx_valid}, 8'h01);
        chkf("R4 standard frame clipped", tx_frame, clip(f));
        expect_reg("R5 buffer busy", 2, 8'h00);
        snap = tx_frame;
        wr(19, 8'hEE);
        chkf("R5 write while pending ignored", tx_frame, snap);
        ack_pulse();
        chk8("R6 tx_valid drops", {7'b0, tx_valid}, 8'h00);
        chk8("R12 irq_o set", {7'b0, irq}, 8'h01);
        expect_reg("R6 buffer free", 2, 8'h04);
        expect_reg("R6 tx irq", 3, 8'h02);
        chk8("R12 irq_o cleared", {7'b0, irq}, 8'h00);
        expect_reg("R12 irq cleared on read", 3, 8'h00);
    endtask

    task automatic t_tx_ext_abort();
        frm_t f = '0;
        logic [28:0] id = 29'h0ABCDEF5;
        f[0] = 8'h8C;
        {f[1], f[2], f[3], f[4]} = {id, 3'b000};
        for (int i = 5; i < 13; i++) f[i] = 8'(i);
        write_frame(f);
        wr(1, 8'h01);
        chkf("R4 extended frame length clipped to 8", tx_frame, f);
        chk8("R4 extended id byte1", tx_frame[1], 8'h55);
        wr(1, 8'h02);
        chk8("R7 abort drops tx_valid", {7'b0, tx_valid}, 8'h00);
        expect_reg("R7 abort no irq", 3, 8'h00);
        wr(1, 8'h01);
        chk8("R7 request again", {7'b0, tx_valid}, 8'h01);
        wr(0, 8'h01);
        chk8("R7 reset mode stops tx", {7'b0, tx_valid}, 8'h00);
        wr(0, 8'h00);
        expect_reg("R7 stop no irq", 3, 8'h00);
    endtask

    task automatic t_cmd_gating();
        wr(0, 8'h01);
        wr(1, 8'h01);
        chk8("R8 command in reset ignored", {7'b0, tx_valid}, 8'h00);
        wr(0, 8'h03); wr(0, 8'h02);
        wr(1, 8'h01);
        chk8("R8 listen-only blocks request", {7'b0, tx_valid}, 8'h00);
        expect_reg("R8 status unchanged", 2, 8'h04);
        wr(0, 8'h03); wr(0, 8'h01); wr(0, 8'h00);
        expect_reg("R8 mode back", 0, 8'h00);
    endtask

    task automatic t_rx_overrun();
        frm_t f = '0, g = '0, h = '0, got;
        logic [7:0] v;
        f[0] = 8'h05; f[1] = 8'h12; f[2] = 8'h34;
        for (int i = 3; i < 8; i++) f[i] = 8'hA0 + 8'(i);
        for (int i = 8; i < 13; i++) f[i] = 8'hEE;
        push(f);
        expect_reg("R9 rx full", 2, 8'h05);
        read_frame(got);
        chkf("R9 stored frame", got, clip(f));
        expect_reg("R9 rx irq", 3, 8'h01);
        g[0] = 8'h01; g[3] = 8'h5A;
        push(g);
        expect_reg("R11 overrun set", 2, 8'h07);
        expect_reg("R11 buffer unchanged", 19, 8'hA3);
        wr(1, 8'h08);
        expect_reg("R11 overrun cleared", 2, 8'h05);
        h[0] = 8'h02; h[1] = 8'h7F; h[3] = 8'hC1; h[4] = 8'hC2; h[5] = 8'hC3;
        @(negedge clk); wr_en = 1; addr = 1; wdata = 8'h04; rx_valid = 1; rx_frame = h;
        @(posedge clk); #1; wr_en = 0; rx_valid = 0;
        expect_reg("R11 release with arrival", 2, 8'h05);
        read_frame(got);
        chkf("R11 new frame stored", got, clip(h));
        wr(1, 8'h04);
        expect_reg("R11 released", 2, 8'h04);
        rd(3, v);
        chk8("R11 irq after race", v, 8'h01);
    endtask

    task automatic t_irq_race();
        frm_t f = '0;
        f[0] = 8'h00; f[1] = 8'h01;
        @(negedge clk); rd_en = 1; addr = 3; rx_valid = 1; rx_frame = f;
        @(posedge clk); #1; rd_en = 0; rx_valid = 0;
        chk8("R12 read before set", rdata, 8'h00);
        chk8("R12 irq_o after race", {7'b0, irq}, 8'h01);
        expect_reg("R12 same-cycle flag kept", 3, 8'h01);
        wr(1, 8'h04);
    endtask

    task automatic t_loop();
        frm_t f = '0, got;
        f[0] = 8'h82; {f[1], f[2], f[3], f[4]} = {29'h1234567, 3'b000};
        f[5] = 8'h3C; f[6] = 8'h4D; f[7] = 8'hFF; f[12] = 8'h81;
        wr(0, 8'h01); wr(0, 8'h05); wr(0, 8'h04);
        write_frame(f);
        wr(1, 8'h10);
        chk8("R13 no tx_valid", {7'b0, tx_valid}, 8'h00);
        expect_reg("R13 looped into rx", 2, 8'h05);
        read_frame(got);
        chkf("R13 looped frame", got, clip(f));
        expect_reg("R13 both irq", 3, 8'h03);
        wr(1, 8'h04);
        wr(0, 8'h01); wr(0, 8'h00);
        wr(1, 8'h10);
        expect_reg("R13 ignored outside self-test", 2, 8'h04);
        expect_reg("R13 no irq outside self-test", 3, 8'h00);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_mode();
        t_filter_regs();
        t_filter();
        t_tx_std();
        t_tx_ext_abort();
        t_cmd_gating();
        t_rx_overrun();
        t_irq_race();
        t_loop();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule